// File: doc/BRIEF.md
# Serial Boot Configuration Word Loader

This block receives a 12-bit processor start-up word from a host bridge over a three-wire serial channel made of a select line, a serial clock and a data line. The word arrives most-significant bit first. A separate user control line decides when the word takes effect. While that line is low, the processor is held in hard reset. When the line goes high, the reset is released and the collected word becomes the active configuration. A word with too few bits leaves the previous configuration in place and raises an error flag.

The active word drives a set of static configuration outputs: bus ownership, memory bank 0 disable, processor slave mode, a 3-bit internal memory base, a high exception-vector location and a free software flag. A 32-bit read view shows the active word and the error flag. All state is cleared by an asynchronous power-on reset or by a synchronous local-bus reset from the bridge. All serial inputs are sampled in the `clk` domain.

Top module: `cfg_word_loader`

## Requirements
- R1: After power-on reset or local-bus reset, the active word is 0x0F0, the error flag is 0 and `cpu_hreset` is 1. The local-bus reset also drops any partly shifted word.
- R2: A data bit is taken on every rising edge of `ser_clk` seen while `ser_sel` is high. The first bit taken becomes bit 11 of the word and the twelfth becomes bit 0.
- R3: Whenever `boot_ctl` is sampled low, `cpu_hreset` is 1 in the next cycle, and it stays 1 for as long as the line is low.
- R4: On a rising edge of `boot_ctl` after 12 bits have been taken, the active word becomes the shifted word, `cpu_hreset` goes to 0 in the next cycle and the error flag clears. The shifted bit count then returns to zero.
- R5: On a rising edge of `boot_ctl` with fewer than 12 bits taken since the last start, the active word is kept and the error flag is set. This includes a second release with no new bits.
- R6: Clock edges seen while `ser_sel` is low are ignored. A rising edge of `ser_sel` restarts the bit count, so the next bit lands in bit 11.
- R7: Bits beyond the twelfth in one selection are ignored, so the first twelve bits are kept.
- R8: The outputs decode the active word as follows: `own_bus` is bit 11, `bank0_off` is bit 10, `slave_mode` is bit 9, `vec_high` is bit 7, `imem_base` is bits 6:4 and `sw_flag` is bit 0.
- R9: `rd_data` carries the active word in bits 11:0 and the error flag in bit 12. Bits 31:13 read as zero. The read is always a whole 32-bit word.
- R10: If the twelfth clock edge falls in the same cycle as the rising edge of `boot_ctl`, that bit counts and the full new word is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lbus_rst | input | 1 | Synchronous local-bus reset, active high |
| ser_sel | input | 1 | Serial channel select |
| ser_clk | input | 1 | Serial clock, sampled in the clk domain |
| ser_din | input | 1 | Serial data |
| boot_ctl | input | 1 | Low holds reset; a rising edge applies the word |
| cpu_hreset | output | 1 | Processor hard reset, active high |
| own_bus | output | 1 | Bridge-only bus ownership |
| bank0_off | output | 1 | Memory bank 0 disabled after reset |
| slave_mode | output | 1 | Processor starts in slave mode |
| imem_base | output | 3 | Internal memory base select |
| vec_high | output | 1 | Exception vectors at the high address |
| sw_flag | output | 1 | Free software flag |
| rd_data | output | 32 | Read view of the active word and error flag |

## Verification
The main concurrency case is the last serial clock edge landing in the same cycle as the release edge of the control line. The bench provokes this by raising both lines at one falling edge of `clk`. It then checks that the full new word is active and that the error flag stayed clear.

A second overlap is the local-bus reset arriving halfway through a shift. The bench checks that the default word returns. It also checks that a later release, made after too few further bits, reports the short-word error.

// File: rtl/cfg_word_loader_pkg.sv
package cfg_word_loader_pkg;
    localparam int CFG_W = 12;
    localparam int CNT_W = $clog2(CFG_W + 1);

    // field positions inside the configuration word
    localparam int POS_OWN   = 11;
    localparam int POS_BANK  = 10;
    localparam int POS_SLAVE = 9;
    localparam int POS_VEC   = 7;
    localparam int POS_BASE  = 4;
    localparam int BASE_W    = 3;
    localparam int POS_FLAG  = 0;

    typedef struct packed {
        logic [CFG_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic             sck;
        logic             sel;
    } shift_st_t;

    typedef struct packed {
        logic [CFG_W-1:0] act;
        logic             err;
        logic             hrst;
        logic             usr;
    } apply_st_t;
endpackage

// File: rtl/cfg_word_shift.sv
module cfg_word_shift
    import cfg_word_loader_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             lbus_rst,
    input  logic             ser_sel,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             consume,
    output logic [CFG_W-1:0] fill_word,
    output logic [CNT_W-1:0] fill_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);

    shift_st_t st_d, st_q;
    logic      sel_rise;
    logic      sck_rise;

    always_comb begin
        st_d     = st_q;
        st_d.sck = ser_clk;
        st_d.sel = ser_sel;
        sel_rise = ser_sel && !st_q.sel;
        sck_rise = ser_sel && ser_clk && !st_q.sck;
        fill_cnt  = sel_rise ? '0 : st_q.cnt;
        fill_word = sel_rise ? '0 : st_q.sh;
        if (sck_rise && fill_cnt != FULL) begin
            fill_word = {fill_word[CFG_W-2:0], ser_din};
            fill_cnt  = fill_cnt + 1'b1;
        end
        st_d.sh  = fill_word;
        st_d.cnt = consume ? '0 : fill_cnt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        st_q <= '0;
        else if (lbus_rst) st_q <= '0;
        else               st_q <= st_d;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt <= FULL);

    assert_sel_low_ignored_R6: assert property (@(posedge clk) disable iff (!por_n || lbus_rst)
        (!ser_sel && !consume) |=> ($stable(st_q.cnt) && $stable(st_q.sh)));

    assert_sel_restart_R6: assert property (@(posedge clk) disable iff (!por_n || lbus_rst)
        (ser_sel && !st_q.sel) |=> (st_q.cnt <= CNT_W'(1)));
endmodule

// File: rtl/cfg_word_apply.sv
module cfg_word_apply
    import cfg_word_loader_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEFAULT_WORD = 12'h0F0
)(
    input  logic             clk,
    input  logic             por_n,
    input  logic             lbus_rst,
    input  logic             boot_ctl,
    input  logic [CFG_W-1:0] fill_word,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             consume,
    output logic [CFG_W-1:0] act_word,
    output logic             err,
    output logic             hreset
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);
    localparam apply_st_t RST = '{act: DEFAULT_WORD, err: 1'b0, hrst: 1'b1, usr: 1'b1};

    apply_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        consume   = boot_ctl && !st_q.usr;
        st_d.usr  = boot_ctl;
        st_d.hrst = !boot_ctl;
        if (consume) begin
            if (fill_cnt == FULL) begin
                st_d.act = fill_word;
                st_d.err = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        st_q <= RST;
        else if (lbus_rst) st_q <= RST;
        else               st_q <= st_d;
    end

    assign act_word = st_q.act;
    assign err      = st_q.err;
    assign hreset   = st_q.hrst;

    assert_hold_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
        !boot_ctl |=> hreset);

    assert_apply_full_R4: assert property (@(posedge clk) disable iff (!por_n || lbus_rst)
        (boot_ctl && !st_q.usr && fill_cnt == FULL)
        |=> (act_word == $past(fill_word) && !hreset && !err));

    assert_keep_short_R5: assert property (@(posedge clk) disable iff (!por_n || lbus_rst)
        (boot_ctl && !st_q.usr && fill_cnt != FULL) |=> ($stable(act_word) && err));

    assert_bus_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
        lbus_rst |=> (act_word == DEFAULT_WORD && hreset && !err));
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
    import cfg_word_loader_pkg::*;
#(
    parameter int               READ_W       = 32,
    parameter logic [CFG_W-1:0] DEFAULT_WORD = 12'h0F0
)(
    input  logic              clk,
    input  logic              por_n,
    input  logic              lbus_rst,
    input  logic              ser_sel,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              boot_ctl,
    output logic              cpu_hreset,
    output logic              own_bus,
    output logic              bank0_off,
    output logic              slave_mode,
    output logic [BASE_W-1:0] imem_base,
    output logic              vec_high,
    output logic              sw_flag,
    output logic [READ_W-1:0] rd_data
);
    logic [CFG_W-1:0] fill_word;
    logic [CNT_W-1:0] fill_cnt;
    logic             consume;
    logic [CFG_W-1:0] act_word;
    logic             err;

    cfg_word_shift u_shift (
        .clk       (clk),
        .por_n     (por_n),
        .lbus_rst  (lbus_rst),
        .ser_sel   (ser_sel),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .consume   (consume),
        .fill_word (fill_word),
        .fill_cnt  (fill_cnt)
    );

    cfg_word_apply #(.DEFAULT_WORD(DEFAULT_WORD)) u_apply (
        .clk       (clk),
        .por_n     (por_n),
        .lbus_rst  (lbus_rst),
        .boot_ctl  (boot_ctl),
        .fill_word (fill_word),
        .fill_cnt  (fill_cnt),
        .consume   (consume),
        .act_word  (act_word),
        .err       (err),
        .hreset    (hreset_w)
    );

    logic hreset_w;

    assign cpu_hreset = hreset_w;
    assign own_bus    = act_word[POS_OWN];
    assign bank0_off  = act_word[POS_BANK];
    assign slave_mode = act_word[POS_SLAVE];
    assign imem_base  = act_word[POS_BASE +: BASE_W];
    assign vec_high   = act_word[POS_VEC];
    assign sw_flag    = act_word[POS_FLAG];
    assign rd_data    = READ_W'({err, act_word});

    assert_release_follows_R3: assert property (@(posedge clk) disable iff (!por_n || lbus_rst)
        (boot_ctl && $past(boot_ctl)) |-> !cpu_hreset);
endmodule

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n, lbus_rst, ser_sel, ser_clk, ser_din, boot_ctl;
    logic        cpu_hreset, own_bus, bank0_off, slave_mode, vec_high, sw_flag;
    logic [2:0]  imem_base;
    logic [31:0] rd_data;

    int          n_chk = 0;
    int          n_err = 0;
    logic [11:0] exp_word;
    logic        exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_word_loader u_cfg_word_loader (
        .clk(clk), .por_n(por_n), .lbus_rst(lbus_rst), .ser_sel(ser_sel),
        .ser_clk(ser_clk), .ser_din(ser_din), .boot_ctl(boot_ctl),
        .cpu_hreset(cpu_hreset), .own_bus(own_bus), .bank0_off(bank0_off),
        .slave_mode(slave_mode), .imem_base(imem_base), .vec_high(vec_high),
        .sw_flag(sw_flag), .rd_data(rd_data)
    );

    function automatic logic [31:0] view_of(input logic [11:0] w, input logic e);
        return {19'd0, e, w};
    endfunction

    // R8 field map computed by the bench
    function automatic logic [7:0] fields_of(input logic [11:0] w);
        return {w[11], w[10], w[9], w[6:4], w[7], w[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_state(input string req);
        check({req, " R9 read view"}, rd_data, view_of(exp_word, exp_err));
        check({req, " R8 fields"},
              {24'd0, own_bus, bank0_off, slave_mode, imem_base, vec_high, sw_flag},
              {24'd0, fields_of(exp_word)});
    endtask

    task automatic shift_bits(input logic [11:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 12) ? w[11-i] : 1'($urandom);
            step();
            ser_clk = 1'b1;
            step();
            step();
            ser_clk = 1'b0;
            step();
        end
    endtask

    task automatic send(input logic [11:0] w, input int n);
        ser_sel = 1'b1;
        step();
        shift_bits(w, n);
        ser_sel = 1'b0;
        step();
    endtask

    task automatic release_and_check(input string req);
        boot_ctl = 1'b1;
        step();
        check({req, " R4 hreset released"}, {31'd0, cpu_hreset}, 32'd0);
        check_state(req);
        boot_ctl = 1'b0;
        step();
        check({req, " R3 hreset reasserted"}, {31'd0, cpu_hreset}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] w;
        void'($urandom(32'd4242));
        por_n = 1'b0; lbus_rst = 1'b0; ser_sel = 1'b0; ser_clk = 1'b0;
        ser_din = 1'b0; boot_ctl = 1'b0;
        repeat (3) step();
        por_n = 1'b1;
        step();
        exp_word = 12'h0F0; exp_err = 1'b0;
        check_state("R1 power-on");
        check("R1 hreset after power-on", {31'd0, cpu_hreset}, 32'd1);
        repeat (5) step();
        check("R3 hreset held while low", {31'd0, cpu_hreset}, 32'd1);

        // R2 / R4 directed word
        send(12'hA5C, 12);
        exp_word = 12'hA5C; exp_err = 1'b0;
        release_and_check("R2 R4 directed");

        // R5 release without new bits
        exp_err = 1'b1;
        release_and_check("R5 no bits");

        // R5 short word
        send(12'h3C3, 7);
        release_and_check("R5 seven bits");

        // R6 select restart and low-select ignore
        ser_sel = 1'b1; step();
        shift_bits(12'hFFF, 5);
        ser_sel = 1'b0; step();
        shift_bits(12'hFFF, 3);
        send(12'h1B6, 12);
        exp_word = 12'h1B6; exp_err = 1'b0;
        release_and_check("R6 restart");

        // R7 extra bits ignored
        send(12'h6E9, 14);
        exp_word = 12'h6E9;
        release_and_check("R7 extra bits");

        // R10 last edge in the release cycle
        w = 12'h935;
        ser_sel = 1'b1; step();
        shift_bits(w, 11);
        ser_din = w[0];
        step();
        ser_clk = 1'b1; boot_ctl = 1'b1;
        step();
        exp_word = w; exp_err = 1'b0;
        check("R10 hreset released", {31'd0, cpu_hreset}, 32'd0);
        check_state("R10 same cycle");
        ser_clk = 1'b0; ser_sel = 1'b0; boot_ctl = 1'b0;
        step(); step();

        // R1 local-bus reset mid shift
        ser_sel = 1'b1; step();
        shift_bits(12'h5A5, 6);
        lbus_rst = 1'b1; step();
        lbus_rst = 1'b0; step();
        exp_word = 12'h0F0; exp_err = 1'b0;
        check_state("R1 bus reset");
        check("R1 hreset after bus reset", {31'd0, cpu_hreset}, 32'd1);
        shift_bits(12'h5A5, 6);
        ser_sel = 1'b0; step();
        exp_err = 1'b1;
        release_and_check("R1 partial dropped");

        // random mix
        for (int it = 0; it < 25; it++) begin
            int n;
            w = 12'($urandom);
            n = ($urandom % 4 == 0) ? int'($urandom % 12) : 12 + int'($urandom % 3);
            send(w, n);
            if (n >= 12) begin
                exp_word = w; exp_err = 1'b0;
            end else begin
                exp_err = 1'b1;
            end
            release_and_check("R4 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule